// File: doc/BRIEF.md
# Secure Scan Chain Controller

This block is a chain of multiplexed-D scan cells with a thin layer of protection logic around it. In normal operation every cell captures one bit of a parallel functional vector on each clock. In test mode the cells can be linked into a serial shift register, loaded from a scan input and unloaded through a scan output. The protection logic stops the chain from leaking state that was captured while the chip ran its functional task.

Two guards provide this protection. First, the shift enable that reaches the cells is qualified by the mode select, so the serial path cannot be opened in functional mode. Second, the block keeps a registered copy of the previous mode select. Any difference between that copy and the current mode marks a mode switch, and in that clock every cell loads zero. Any capture made in one mode is therefore gone before the other mode can observe it.

The clear is synchronous and active high. It is the OR of the system reset and the switch-detect term. The previous-mode register itself resets to the functional value (0).

Top module: `secure_scan_ctrl`

## Requirements
- R1: On every clock edge at which `sysRst` is 1, all cells load 0, whatever `modeSel`, `shiftEnPin`, `scanIn` or `funcData` hold.
- R2: In functional mode (`modeSel` 0 on this edge and on the previous one, no reset), every cell loads its bit of `funcData` on each edge.
- R3: In functional mode, `shiftEnPin` = 1 has no effect: the cells still load `funcData` and no serial shift takes place.
- R4: In test mode (`modeSel` 1 on this edge and on the previous one, no reset) with `shiftEnPin` 1, cell 0 loads `scanIn` and cell i loads the old value of cell i-1. Bit 0 of `regOut` is cell 0.
- R5: In test mode with `shiftEnPin` 0 (capture), every cell loads its bit of `funcData`.
- R6: On the edge at which `modeSel` reads 1 and the previous edge read 0 (functional to test), all cells load 0, whatever the shift enable and data are.
- R7: On the edge at which `modeSel` reads 0 and the previous edge read 1 (test to functional), all cells load 0, whatever the shift enable and data are.
- R8: The stored previous mode is 0 after reset. Leaving reset with `modeSel` 0 therefore causes no clear, and the first edge loads `funcData`. Leaving reset with `modeSel` 1 counts as a switch and clears once.
- R9: The clear lasts one edge only. On the next edge in the same mode, the cells follow R2 to R5 again.
- R10: `regOut` always shows the cell contents, and `scanOut` always equals the top cell, `regOut[CHAIN_LEN-1]`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for all cells and the mode history register |
| sysRst | input | 1 | Synchronous active-high system reset |
| modeSel | input | 1 | Working mode: 0 functional, 1 test |
| shiftEnPin | input | 1 | External shift request, honoured only in test mode |
| scanIn | input | 1 | Serial data into cell 0 |
| funcData | input | CHAIN_LEN | Parallel functional data, one bit per cell |
| regOut | output | CHAIN_LEN | Parallel cell contents |
| scanOut | output | 1 | Serial output, the top cell |

## Verification
The hardest case is the clear itself. It happens only on the single edge where the current mode differs from the mode of the previous edge, and the result depends on which of the four shift/data combinations is present in that same cycle. The stimulus first settles each of the two modes for several cycles with known contents, then makes the switch with every combination of shift enable and data pattern. Reset release is also exercised under both mode values. After that, a long pseudo-random stream of mode, shift, serial and parallel inputs runs against a bench-side model.

// File: rtl/secscan_pkg.sv
package secscan_pkg;

  // Strobes from the guard control to every scan cell.
  typedef struct packed {
    logic clear;  // synchronous clear: load all-zero this edge
    logic shift;  // qualified shift: take predecessor instead of functional bit
  } cellCtrl_t;

endpackage

// File: rtl/scan_guard_ctrl.sv
module scan_guard_ctrl
  import secscan_pkg::*;
(
  input  logic      clk,
  input  logic      sysRst,
  input  logic      modeSel,
  input  logic      shiftEnPin,
  output cellCtrl_t cellCtrl
);

  logic prevMode;
  logic switchSeen;

  // History of the working mode; reset to functional.
  always_ff @(posedge clk) begin
    if (sysRst) prevMode <= 1'b0;
    else        prevMode <= modeSel;
  end

  always_comb begin
    switchSeen     = prevMode ^ modeSel;
    cellCtrl.clear = sysRst | switchSeen;
    cellCtrl.shift = shiftEnPin & modeSel;
  end

endmodule

// File: rtl/scan_cell.sv
module scan_cell
  import secscan_pkg::*;
(
  input  logic      clk,
  input  cellCtrl_t cellCtrl,
  input  logic      funcBit,
  input  logic      serialIn,
  output logic      cellQ
);

  always_ff @(posedge clk) begin
    if (cellCtrl.clear)      cellQ <= 1'b0;
    else if (cellCtrl.shift) cellQ <= serialIn;
    else                     cellQ <= funcBit;
  end

endmodule

// File: rtl/scan_chain.sv
module scan_chain
  import secscan_pkg::*;
#(
  parameter int CHAIN_LEN = 16
) (
  input  logic                 clk,
  input  cellCtrl_t            cellCtrl,
  input  logic                 scanIn,
  input  logic [CHAIN_LEN-1:0] funcData,
  output logic [CHAIN_LEN-1:0] cellState,
  output logic                 scanOut
);

  localparam int TOP_IDX = CHAIN_LEN - 1;

  logic [CHAIN_LEN-1:0] linkIn;

  for (genvar idx = 0; idx < CHAIN_LEN; idx++) begin : g_cell
    if (idx == 0) begin : g_head
      assign linkIn[idx] = scanIn;
    end else begin : g_body
      assign linkIn[idx] = cellState[idx-1];
    end

    scan_cell uCell (
      .clk      (clk),
      .cellCtrl (cellCtrl),
      .funcBit  (funcData[idx]),
      .serialIn (linkIn[idx]),
      .cellQ    (cellState[idx])
    );
  end

  assign scanOut = cellState[TOP_IDX];

endmodule

// File: rtl/secure_scan_ctrl.sv
module secure_scan_ctrl
  import secscan_pkg::*;
#(
  parameter int CHAIN_LEN = 16
) (
  input  logic                 clk,
  input  logic                 sysRst,
  input  logic                 modeSel,
  input  logic                 shiftEnPin,
  input  logic                 scanIn,
  input  logic [CHAIN_LEN-1:0] funcData,
  output logic [CHAIN_LEN-1:0] regOut,
  output logic                 scanOut
);

  cellCtrl_t cellCtrl;

  scan_guard_ctrl uGuard (
    .clk        (clk),
    .sysRst     (sysRst),
    .modeSel    (modeSel),
    .shiftEnPin (shiftEnPin),
    .cellCtrl   (cellCtrl)
  );

  scan_chain #(.CHAIN_LEN(CHAIN_LEN)) uChain (
    .clk       (clk),
    .cellCtrl  (cellCtrl),
    .scanIn    (scanIn),
    .funcData  (funcData),
    .cellState (regOut),
    .scanOut   (scanOut)
  );

endmodule

// File: rtl/secure_scan_chk.sv
module secure_scan_chk #(
  parameter int CHAIN_LEN = 16
) (
  input logic                 clk,
  input logic                 sysRst,
  input logic                 modeSel,
  input logic                 shiftEnPin,
  input logic                 scanIn,
  input logic [CHAIN_LEN-1:0] funcData,
  input logic [CHAIN_LEN-1:0] regOut,
  input logic                 scanOut
);

  // R1
  reset_clears_chk: assert property (@(posedge clk)
    sysRst |=> regOut == '0);

  // R2 R3
  func_loads_chk: assert property (@(posedge clk) disable iff (sysRst)
    (!modeSel && !$past(modeSel)) |=> regOut == $past(funcData));

  // R4
  shift_moves_chk: assert property (@(posedge clk) disable iff (sysRst)
    (modeSel && $past(modeSel) && !$past(sysRst) && shiftEnPin)
      |=> regOut == {$past(regOut[CHAIN_LEN-2:0]), $past(scanIn)});

  // R5
  capture_loads_chk: assert property (@(posedge clk) disable iff (sysRst)
    (modeSel && $past(modeSel) && !$past(sysRst) && !shiftEnPin)
      |=> regOut == $past(funcData));

  // R6 R7
  switch_clears_chk: assert property (@(posedge clk) disable iff (sysRst)
    (modeSel != $past(modeSel) && !$past(sysRst)) |=> regOut == '0);

  // R10
  serial_tail_chk: assert property (@(posedge clk) disable iff (sysRst)
    (modeSel && $past(modeSel) && !$past(sysRst) && shiftEnPin)
      |=> scanOut == $past(regOut[CHAIN_LEN-2]));

endmodule

bind secure_scan_ctrl secure_scan_chk #(.CHAIN_LEN(CHAIN_LEN)) uChk (
  .clk        (clk),
  .sysRst     (sysRst),
  .modeSel    (modeSel),
  .shiftEnPin (shiftEnPin),
  .scanIn     (scanIn),
  .funcData   (funcData),
  .regOut     (regOut),
  .scanOut    (scanOut)
);

// File: tb/tb_secure_scan_ctrl.sv
module tb_secure_scan_ctrl;

  localparam int CLK_PERIOD = 10;
  localparam int N = 16;

  logic         clk = 1'b0;
  logic         sysRst = 1'b1;
  logic         modeSel = 1'b0;
  logic         shiftEnPin = 1'b0;
  logic         scanIn = 1'b0;
  logic [N-1:0] funcData = '0;
  logic [N-1:0] regOut;
  logic         scanOut;

  int checks = 0;
  int fails = 0;
  logic [N-1:0] model = '0;
  logic         modelPrev = 1'b0;
  bit           done = 1'b0;

  secure_scan_ctrl #(.CHAIN_LEN(N)) dut (
    .clk(clk), .sysRst(sysRst), .modeSel(modeSel), .shiftEnPin(shiftEnPin),
    .scanIn(scanIn), .funcData(funcData), .regOut(regOut), .scanOut(scanOut)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic string pickTag(input logic rst, input logic m,
                                    input logic pm, input logic sh);
    if (rst)          return "R1";
    if (m && !pm)     return "R6";
    if (!m && pm)     return "R7";
    if (m && sh)      return "R4";
    if (m)            return "R5";
    if (sh)           return "R3";
    return "R2";
  endfunction

  task automatic compare(input string tag, input logic [N-1:0] exp);
    checks++;
    if (regOut !== exp) begin
      fails++;
      $display("FAIL %s regOut got %h expected %h", tag, regOut, exp);
    end
    checks++;
    if (scanOut !== exp[N-1]) begin
      fails++;
      $display("FAIL R10 (%s) scanOut got %b expected %b", tag, scanOut, exp[N-1]);
    end
  endtask

  // One clock: drive at the falling edge, check 1 time unit after the rising edge.
  task automatic cycle(input logic rst, input logic m, input logic sh,
                       input logic si, input logic [N-1:0] fd, input string extra);
    string tag;
    @(negedge clk);
    sysRst = rst; modeSel = m; shiftEnPin = sh; scanIn = si; funcData = fd;
    tag = pickTag(rst, m, modelPrev, sh);
    if (extra != "") tag = {extra, " ", tag};
    if (rst || (m != modelPrev)) model = '0;
    else if (m && sh)            model = {model[N-2:0], si};
    else                         model = fd;
    modelPrev = rst ? 1'b0 : m;
    @(posedge clk);
    #1;
    compare(tag, model);
  endtask

  initial begin
    logic [N-1:0] pats [4];
    logic [N-1:0] shiftWord;
    pats[0] = 16'hA5C3; pats[1] = 16'hFFFF; pats[2] = 16'h0001; pats[3] = 16'h8000;

    // Reset with busy inputs (R1)
    cycle(1, 1, 1, 1, 16'hFFFF, "R1");
    cycle(1, 0, 1, 1, 16'h1234, "R1");
    // Release in functional mode: no spurious clear (R8)
    cycle(0, 0, 0, 0, 16'h5A5A, "R8");
    cycle(0, 0, 1, 1, 16'h0F0F, "R3");

    // Sweep: settle previous mode, then switch or stay with every combo (R6 R7 R9)
    for (int pm = 0; pm < 2; pm++)
      for (int m = 0; m < 2; m++)
        for (int sh = 0; sh < 2; sh++)
          for (int p = 0; p < 4; p++) begin
            cycle(0, pm[0], 1'b0, 1'b1, pats[p] ^ 16'h3C3C, "");
            cycle(0, pm[0], 1'b1, 1'b1, pats[(p+1)%4], "");
            cycle(0, m[0], sh[0], p[0], pats[p], "");
            cycle(0, m[0], sh[0], ~p[0], pats[3-p], "R9");
            cycle(0, m[0], ~sh[0], 1'b1, ~pats[p], "R9");
          end

    // Serial load then unload through scanOut (R4 R10)
    cycle(0, 1, 0, 0, 16'h0000, "");
    cycle(0, 1, 0, 0, 16'h0000, "R5");
    shiftWord = 16'hC6B1;
    for (int i = 0; i < N; i++)
      cycle(0, 1, 1, shiftWord[N-1-i], 16'hFFFF, "R4");
    for (int i = 0; i < N; i++) begin
      checks++;
      if (scanOut !== shiftWord[N-1-i]) begin
        fails++;
        $display("FAIL R4 serial bit %0d got %b expected %b", i, scanOut, shiftWord[N-1-i]);
      end
      cycle(0, 1, 1, 1'b0, 16'hFFFF, "R4");
    end

    // Reset released with modeSel held at 1: counts as a switch (R8)
    cycle(1, 1, 1, 1, 16'hFFFF, "R1");
    cycle(0, 1, 1, 1, 16'hFFFF, "R8");
    cycle(0, 1, 1, 1, 16'hFFFF, "R9");

    // Pseudo-random stream
    for (int k = 0; k < 3000; k++) begin
      logic [31:0] r;
      r = $urandom;
      cycle((r[7:0] == 8'h00), (r[12:10] != 3'd0) ? modelPrev : ~modelPrev,
            r[13], r[14], r[31:16], "");
    end

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

endmodule